// File: doc/BRIEF.md
# Snooping Line Controller with Writeback-Race Trap

This block holds the coherence state of one cache line for a node in a broadcast snooping system that keeps the usual Modified, Owned, Shared and Invalid states. The processor side asks for reads, writes and evictions. The controller answers hits locally and turns misses, upgrades and dirty evictions into requests for the shared, totally ordered request bus. It also watches every request that appears on that bus. A request that carries the controller's own node number marks the point where its own transaction takes effect. A request from any other node moves the line to a weaker state when one is needed.

One race is left unhandled on purpose. The line can be evicted from M or O, and then two different nodes can ask for exclusive ownership before the node's own writeback shows up on the bus. The controller does not resolve that case. It parks the line in a trap state and raises a recovery flag, so that a system-level rollback can run the work again under different timing. The first exclusive requester seen during the writeback window is remembered, and that node becomes responsible for the data. If the writeback reaches the bus before a second requester appears, the line simply goes Invalid.

Bus arbitration and the data path are not part of this block.

Top module: `wbtrap_line_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the line goes to Invalid (`line_state`=0), `req_valid` and `recover` are low. Reset is synchronous and active high.
- R2: A processor request leads to a bus request that is visible in the cycle after the processor input is sampled, with `req_valid` high for one cycle. A read in Invalid issues read-shared (`req_type`=00) and moves the line to pending-shared (4). A write in Invalid, Shared or Owned issues read-exclusive (01) and moves the line to pending-exclusive (5).
- R3: A snooped request whose source equals `NODE_ID` completes the node's own transaction. A read-shared (00) moves pending-shared to Shared (1). A read-exclusive (01) moves pending-exclusive to Modified (3).
- R4: Some processor requests need no bus request and leave the state unchanged: a read in Shared, Owned or Modified, and a write in Modified. An eviction in Shared drops the line to Invalid without a request.
- R5: A read-shared (00) from another node moves Modified to Owned (2) and leaves every other stable state unchanged. A read-exclusive (01) from another node moves Shared, Owned or Modified to Invalid. Snoop type 11 changes nothing.
- R6: An eviction in Modified or Owned issues a writeback (`req_type`=10) and moves the line to writeback-pending (6).
- R7: In writeback-pending, the node's own writeback moves the line to Invalid. A read-shared from another node leaves the line in writeback-pending.
- R8: In writeback-pending, a read-exclusive from another node moves the line to the second pending state (7) and records that node's number.
- R9: In the second pending state, the node's own writeback moves the line to Invalid and `recover` stays low.
- R10: In the second pending state, a read-exclusive from a node that is neither this node nor the recorded one moves the line to the trap state (8), and `recover` goes high in the next cycle. A repeated read-exclusive from the recorded node, or a read-exclusive from this node, has no effect.
- R11: Once in the trap state, the line stays there and `recover` stays high until reset. Processor and snoop inputs have no effect.
- R12: The processor inputs are ignored in any pending or trap state and in any cycle with `snp_valid` high. When several are high at once, eviction wins over write, and write wins over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Processor read of the line |
| cpu_wr | input | 1 | Processor write of the line |
| cpu_evict | input | 1 | Processor eviction of the line |
| snp_valid | input | 1 | A request is present on the ordered bus this cycle |
| snp_src | input | NODE_W | Node number of the snooped request's sender |
| snp_type | input | 2 | Snooped request kind: 00 read-shared, 01 read-exclusive, 10 writeback, 11 none |
| req_valid | output | 1 | One-cycle pulse: request to put on the bus |
| req_type | output | 2 | Kind of the issued request, same coding as `snp_type` |
| line_state | output | 4 | Current line state: 0 I, 1 S, 2 O, 3 M, 4 pending-shared, 5 pending-exclusive, 6 writeback-pending, 7 second pending, 8 trap |
| recover | output | 1 | Mis-speculation flag, held until reset |

## Verification
The state is brought out directly, so a wrong transition shows on `line_state` in the cycle right after the input that caused it. A wrong issue decision shows as a missing or extra `req_valid` pulse one cycle after the processor input. A requester number recorded wrongly in the writeback window is visible only indirectly: a repeat request from the first requester would raise `recover` one cycle later, or a genuine second requester would fail to raise it. For that reason the trap sequence is driven with both the same node and a different node. A trap state that leaks shows as `line_state` or `recover` changing after further processor or snoop inputs.

// File: rtl/wbtrap_pkg.sv
package wbtrap_pkg;

  typedef enum logic [1:0] {
    BUS_RDS = 2'b00,
    BUS_RDX = 2'b01,
    BUS_WB  = 2'b10,
    BUS_NOP = 2'b11
  } bus_op_e;

  typedef enum logic [3:0] {
    LN_I    = 4'd0,
    LN_S    = 4'd1,
    LN_O    = 4'd2,
    LN_M    = 4'd3,
    LN_ISP  = 4'd4,
    LN_IMP  = 4'd5,
    LN_WB1  = 4'd6,
    LN_WB2  = 4'd7,
    LN_TRAP = 4'd8
  } line_st_e;

  typedef enum logic [1:0] {
    CPU_NONE = 2'd0,
    CPU_RD   = 2'd1,
    CPU_WR   = 2'd2,
    CPU_EV   = 2'd3
  } cpu_op_e;

endpackage

// File: rtl/wbtrap_snoop_decode.sv
module wbtrap_snoop_decode
  import wbtrap_pkg::*;
#(
  parameter int NODE_W  = 3,
  parameter int NODE_ID = 2
) (
  input  logic              snp_valid,
  input  logic [NODE_W-1:0] snp_src,
  input  logic [1:0]        snp_type,
  input  logic [NODE_W-1:0] first_req,
  output logic              own_rds,
  output logic              own_rdx,
  output logic              own_wb,
  output logic              oth_rds,
  output logic              oth_rdx,
  output logic              oth_rdx_new
);
  localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);

  logic is_self;
  logic is_rds, is_rdx, is_wb;

  always_comb begin
    is_self     = (snp_src == SELF);
    is_rds      = snp_valid && (snp_type == BUS_RDS);
    is_rdx      = snp_valid && (snp_type == BUS_RDX);
    is_wb       = snp_valid && (snp_type == BUS_WB);
    own_rds     = is_rds && is_self;
    own_rdx     = is_rdx && is_self;
    own_wb      = is_wb && is_self;
    oth_rds     = is_rds && !is_self;
    oth_rdx     = is_rdx && !is_self;
    oth_rdx_new = oth_rdx && (snp_src != first_req);
  end
endmodule

// File: rtl/wbtrap_cpu_arb.sv
module wbtrap_cpu_arb
  import wbtrap_pkg::*;
(
  input  logic    cpu_rd,
  input  logic    cpu_wr,
  input  logic    cpu_evict,
  input  logic    snp_valid,
  output cpu_op_e op
);
  always_comb begin
    if (snp_valid)      op = CPU_NONE;
    else if (cpu_evict) op = CPU_EV;
    else if (cpu_wr)    op = CPU_WR;
    else if (cpu_rd)    op = CPU_RD;
    else                op = CPU_NONE;
  end
endmodule

// File: rtl/wbtrap_line_fsm.sv
module wbtrap_line_fsm
  import wbtrap_pkg::*;
#(
  parameter int NODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  cpu_op_e           op,
  input  logic              own_rds,
  input  logic              own_rdx,
  input  logic              own_wb,
  input  logic              oth_rds,
  input  logic              oth_rdx,
  input  logic              oth_rdx_new,
  input  logic [NODE_W-1:0] snp_src,
  output line_st_e          st_q,
  output logic [NODE_W-1:0] first_req_q,
  output logic              iss_v,
  output bus_op_e           iss_op,
  output logic              trap_evt
);
  line_st_e st_d;
  logic     cap_req;

  always_comb begin
    st_d     = st_q;
    iss_v    = 1'b0;
    iss_op   = BUS_NOP;
    trap_evt = 1'b0;
    cap_req  = 1'b0;
    case (st_q)
      LN_I: begin
        if (op == CPU_RD) begin
          iss_v = 1'b1; iss_op = BUS_RDS; st_d = LN_ISP;
        end else if (op == CPU_WR) begin
          iss_v = 1'b1; iss_op = BUS_RDX; st_d = LN_IMP;
        end
      end
      LN_S: begin
        if (oth_rdx) st_d = LN_I;
        else if (op == CPU_WR) begin
          iss_v = 1'b1; iss_op = BUS_RDX; st_d = LN_IMP;
        end else if (op == CPU_EV) st_d = LN_I;
      end
      LN_O: begin
        if (oth_rdx) st_d = LN_I;
        else if (op == CPU_WR) begin
          iss_v = 1'b1; iss_op = BUS_RDX; st_d = LN_IMP;
        end else if (op == CPU_EV) begin
          iss_v = 1'b1; iss_op = BUS_WB; st_d = LN_WB1;
        end
      end
      LN_M: begin
        if (oth_rdx) st_d = LN_I;
        else if (oth_rds) st_d = LN_O;
        else if (op == CPU_EV) begin
          iss_v = 1'b1; iss_op = BUS_WB; st_d = LN_WB1;
        end
      end
      LN_ISP: if (own_rds) st_d = LN_S;
      LN_IMP: if (own_rdx) st_d = LN_M;
      LN_WB1: begin
        if (own_wb) st_d = LN_I;
        else if (oth_rdx) begin
          st_d = LN_WB2; cap_req = 1'b1;
        end
      end
      LN_WB2: begin
        if (own_wb) st_d = LN_I;
        else if (oth_rdx_new) begin
          st_d = LN_TRAP; trap_evt = 1'b1;
        end
      end
      LN_TRAP: st_d = LN_TRAP;
      default: st_d = LN_I;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= LN_I;
      first_req_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_req) first_req_q <= snp_src;
    end
  end

  // R10: the second pending state only leaves for Invalid or the trap
  assert_wb2_exit_R10: assert property (@(posedge clk) disable iff (rst)
    st_q == LN_WB2 |=> (st_q == LN_WB2 || st_q == LN_I || st_q == LN_TRAP));

  // R11: trap is absorbing
  assert_trap_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    st_q == LN_TRAP |=> st_q == LN_TRAP);

  // R8: entry to the second pending state only from writeback-pending
  assert_wb2_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == LN_WB2) |-> $past(st_q) == LN_WB1);
endmodule

// File: rtl/wbtrap_out_reg.sv
module wbtrap_out_reg
  import wbtrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       iss_v,
  input  bus_op_e    iss_op,
  input  logic       trap_evt,
  output logic       req_valid,
  output logic [1:0] req_type,
  output logic       recover
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_type  <= BUS_NOP;
      recover   <= 1'b0;
    end else begin
      req_valid <= iss_v;
      req_type  <= iss_v ? iss_op : BUS_NOP;
      if (trap_evt) recover <= 1'b1;
    end
  end

  // R11: once raised, the flag holds until reset
  assert_recover_hold_R11: assert property (@(posedge clk) disable iff (rst)
    recover |=> recover);
endmodule

// File: rtl/wbtrap_line_ctrl.sv
module wbtrap_line_ctrl
  import wbtrap_pkg::*;
#(
  parameter int NODE_W  = 3,
  parameter int NODE_ID = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_evict,
  input  logic              snp_valid,
  input  logic [NODE_W-1:0] snp_src,
  input  logic [1:0]        snp_type,
  output logic              req_valid,
  output logic [1:0]        req_type,
  output logic [3:0]        line_state,
  output logic              recover
);
  localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);

  cpu_op_e           op;
  line_st_e          st_q;
  logic [NODE_W-1:0] first_req_q;
  logic own_rds, own_rdx, own_wb, oth_rds, oth_rdx, oth_rdx_new;
  logic    iss_v, trap_evt;
  bus_op_e iss_op;

  wbtrap_cpu_arb u_arb (
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_evict(cpu_evict),
    .snp_valid(snp_valid), .op(op)
  );

  wbtrap_snoop_decode #(.NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_dec (
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_type(snp_type),
    .first_req(first_req_q),
    .own_rds(own_rds), .own_rdx(own_rdx), .own_wb(own_wb),
    .oth_rds(oth_rds), .oth_rdx(oth_rdx), .oth_rdx_new(oth_rdx_new)
  );

  wbtrap_line_fsm #(.NODE_W(NODE_W)) u_fsm (
    .clk(clk), .rst(rst), .op(op),
    .own_rds(own_rds), .own_rdx(own_rdx), .own_wb(own_wb),
    .oth_rds(oth_rds), .oth_rdx(oth_rdx), .oth_rdx_new(oth_rdx_new),
    .snp_src(snp_src), .st_q(st_q), .first_req_q(first_req_q),
    .iss_v(iss_v), .iss_op(iss_op), .trap_evt(trap_evt)
  );

  wbtrap_out_reg u_out (
    .clk(clk), .rst(rst), .iss_v(iss_v), .iss_op(iss_op),
    .trap_evt(trap_evt), .req_valid(req_valid), .req_type(req_type),
    .recover(recover)
  );

  assign line_state = st_q;

  // R2 / R12: a request pulse always follows a processor input in a snoop-free cycle
  assert_issue_cause_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($past(cpu_rd || cpu_wr || cpu_evict) && !$past(snp_valid)));

  // R10: recovery is raised only by a foreign read-exclusive
  assert_recover_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(recover) |-> $past(snp_valid && snp_type == 2'b01 && snp_src != SELF));

  // R9: own writeback closes the second pending state
  assert_own_wb_done_R9: assert property (@(posedge clk) disable iff (rst)
    (line_state == 4'd7 && snp_valid && snp_type == 2'b10 && snp_src == SELF)
      |=> (line_state == 4'd0 && !recover));
endmodule

// File: tb/wbtrap_line_ctrl_test.sv
`timescale 1ns/1ps
module wbtrap_line_ctrl_test;
  localparam int NW = 3;
  localparam int ME = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_rd = 0, cpu_wr = 0, cpu_evict = 0, snp_valid = 0;
  logic [NW-1:0] snp_src = '0;
  logic [1:0] snp_type = 2'b11;
  logic req_valid, recover;
  logic [1:0] req_type;
  logic [3:0] line_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wbtrap_line_ctrl #(.NODE_W(NW), .NODE_ID(ME)) uut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_evict(cpu_evict), .snp_valid(snp_valid), .snp_src(snp_src),
    .snp_type(snp_type), .req_valid(req_valid), .req_type(req_type),
    .line_state(line_state), .recover(recover)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic rd, input logic wr, input logic ev,
                       input logic sv, input int src, input logic [1:0] typ);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_evict = ev;
    snp_valid = sv; snp_src = NW'(src); snp_type = typ;
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0; cpu_evict = 0; snp_valid = 0; snp_type = 2'b11;
  endtask

  task automatic cpu(input logic rd, input logic wr, input logic ev);
    apply(rd, wr, ev, 1'b0, 0, 2'b11);
  endtask

  task automatic snoop(input int src, input logic [1:0] typ);
    apply(1'b0, 1'b0, 1'b0, 1'b1, src, typ);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", line_state, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 recover", recover, 0);
  endtask

  task automatic t_read_miss();
    cpu(1, 0, 0);
    chk("R2 rd req_valid", req_valid, 1);
    chk("R2 rd req_type", req_type, 0);
    chk("R2 rd state", line_state, 4);
    snoop(ME, 2'b00);
    chk("R3 own rds state", line_state, 1);
    chk("R2 pulse ends", req_valid, 0);
  endtask

  task automatic t_upgrade();
    cpu(1, 0, 0);
    chk("R4 S read hit state", line_state, 1);
    chk("R4 S read hit no req", req_valid, 0);
    cpu(0, 1, 0);
    chk("R2 wr req_type", req_type, 1);
    chk("R2 wr state", line_state, 5);
    cpu(0, 1, 0);
    chk("R12 ignored in pending", req_valid, 0);
    snoop(ME, 2'b01);
    chk("R3 own rdx state", line_state, 3);
    cpu(0, 1, 0);
    chk("R4 M write hit no req", req_valid, 0);
    chk("R4 M write hit state", line_state, 3);
  endtask

  task automatic t_owned_evict();
    snoop(5, 2'b00);
    chk("R5 M to O", line_state, 2);
    snoop(5, 2'b11);
    chk("R5 type 11 ignored", line_state, 2);
    cpu(0, 0, 1);
    chk("R6 O evict req_valid", req_valid, 1);
    chk("R6 O evict req_type", req_type, 2);
    chk("R6 O evict state", line_state, 6);
    snoop(4, 2'b00);
    chk("R7 other rds in WB1", line_state, 6);
    snoop(ME, 2'b10);
    chk("R7 own wb to I", line_state, 0);
  endtask

  task automatic t_snoop_priority();
    apply(1, 0, 0, 1'b1, 4, 2'b00);
    chk("R12 cpu blocked by snoop req", req_valid, 0);
    chk("R12 cpu blocked by snoop state", line_state, 0);
    cpu(1, 0, 0); snoop(ME, 2'b00);
    cpu(0, 0, 1);
    chk("R4 S evict silent state", line_state, 0);
    chk("R4 S evict silent req", req_valid, 0);
    cpu(1, 0, 0); snoop(ME, 2'b00);
    snoop(6, 2'b01);
    chk("R5 S invalidated", line_state, 0);
  endtask

  task automatic t_wb_race_benign();
    cpu(0, 1, 0); snoop(ME, 2'b01);
    chk("R3 reach M", line_state, 3);
    apply(1, 1, 1, 1'b0, 0, 2'b11);
    chk("R12 evict priority type", req_type, 2);
    chk("R6 M evict state", line_state, 6);
    snoop(5, 2'b01);
    chk("R8 to WB2", line_state, 7);
    snoop(ME, 2'b10);
    chk("R9 own wb to I", line_state, 0);
    chk("R9 no recover", recover, 0);
  endtask

  task automatic t_trap();
    cpu(0, 1, 0); snoop(ME, 2'b01); cpu(0, 0, 1);
    snoop(5, 2'b01);
    chk("R8 WB2 again", line_state, 7);
    snoop(5, 2'b01);
    chk("R10 repeat requester ignored", line_state, 7);
    chk("R10 repeat no recover", recover, 0);
    snoop(ME, 2'b01);
    chk("R10 own rdx ignored", line_state, 7);
    snoop(1, 2'b01);
    chk("R10 trap state", line_state, 8);
    chk("R10 recover raised", recover, 1);
    cpu(1, 0, 0);
    chk("R11 cpu ignored req", req_valid, 0);
    snoop(ME, 2'b10);
    chk("R11 snoop ignored state", line_state, 8);
    chk("R11 recover held", recover, 1);
    do_reset();
    chk("R1 reset clears state", line_state, 0);
    chk("R1 reset clears recover", recover, 0);
  endtask

  initial begin
    t_reset();
    t_read_miss();
    t_upgrade();
    t_owned_evict();
    t_snoop_priority();
    t_wb_race_benign();
    t_trap();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule